// File: doc/BRIEF.md
# One-Wire Bit-Slot Timing Engine

This block owns a single open-drain one-wire line and turns one request into one timed bus slot: a bus reset with presence detect, a write-0 slot, a write-1 slot or a read slot. It pulls the line low through an active-low drive enable and later releases it. At a fixed offset after the release it samples a two-flop synchronised copy of the line. When the slot ends it reports the sampled bit with a one-cycle done pulse. Byte assembly, strong pull-up control and pad circuits belong to the surrounding logic.

Every duration is a whole number of microseconds. A prescaler of `CLK_PER_US` clocks sets the length of one microsecond, and every duration is also multiplied by `DELAY_COEF`. The prescaler restarts when a request is accepted, so each slot lasts an exact number of clocks: `us * DELAY_COEF * CLK_PER_US`.

Requests use a valid/ready handshake. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the engine is idle, so a requester holding `req_valid` is simply stalled until the current slot ends. The result has no back-pressure: `rsp_bit` is valid only in the cycle `done` is high, and the consumer must capture it then.

Top module: `ow_slot_engine`

## Requirements
- R1: After reset, `ow_drive_n` is 1 (line released), `busy` is 0, `req_ready` is 1 and `done` is 0.
- R2: `req_op` is encoded as 0 = bus reset, 1 = write (`req_data` gives the bit), 2 = read, 3 = touch. A request is taken only when `req_valid` and `req_ready` are both high. `req_ready` is low while `busy` is high, and requests offered during a slot have no effect on that slot or on the state after it.
- R3: A write-1 slot holds the line low for 6 us, then releases it for 64 us. Done comes 70 us after acceptance and the reported bit is 0.
- R4: A write-0 slot holds the line low for 60 us, then releases it for 10 us. Done comes 70 us after acceptance and the reported bit is 0.
- R5: A read slot holds the line low for 6 us. It samples the synchronised line 9 us after the release, which is 15 us after acceptance. It reports done 55 us later, 70 us after acceptance. The reported bit is the sampled level.
- R6: A bus reset holds the line low for 500 us and samples 70 us after the release. It then waits 430 us of recovery before done. The reported bit is 0 when the line was low at the sample (a device is present) and 1 otherwise.
- R7: One microsecond is `CLK_PER_US` clocks, counted from the acceptance edge, and every duration is multiplied by `DELAY_COEF`.
- R8: A touch with data 1 performs a read slot and returns the sample. A touch with data 0 performs a write-0 slot and returns 0.
- R9: `done` is a single-cycle pulse. `busy` is high from the cycle after acceptance until the cycle in which `done` is high, where it is already low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_op | input | 2 | Slot operation code (see R2) |
| req_data | input | 1 | Data bit for write and touch |
| busy | output | 1 | Slot in progress |
| done | output | 1 | One-cycle end-of-slot pulse |
| rsp_bit | output | 1 | Result bit, valid with `done` |
| ow_drive_n | output | 1 | Active-low line drive enable (0 pulls the line low) |
| ow_line_i | input | 1 | Line level from the pad |

## Verification
The bound checker watches the handshake and status rules on every cycle:
- acceptance must pull the line low and raise busy;
- ready stays low while busy;
- done is a lone pulse that leaves the engine idle;
- the line is released whenever the engine is idle;
- every low stretch lies between the shortest and the longest allowed low time.

Only the bench scenarios can show the exact length of each slot type, the sample instant, the polarity of presence and read results, the mapping of touch requests, and that a request offered mid-slot leaves no trace.

// File: rtl/ow_pkg.sv
package ow_pkg;

  typedef enum logic [1:0] {
    OP_RESET = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_TOUCH = 2'd3
  } ow_op_e;

  typedef enum logic [1:0] {
    SLOT_RST = 2'd0,
    SLOT_W0  = 2'd1,
    SLOT_W1  = 2'd2,
    SLOT_RD  = 2'd3
  } slot_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_REL  = 2'd2,
    PH_TAIL = 2'd3
  } phase_e;

  localparam int US_W = 10;

  // durations in microseconds: low time, release-to-sample, sample-to-done
  typedef struct packed {
    logic [US_W-1:0] low_us;
    logic [US_W-1:0] rel_us;
    logic [US_W-1:0] tail_us;
  } slot_us_t;

  function automatic slot_us_t slot_us(slot_e s);
    slot_us_t t;
    unique case (s)
      SLOT_RST: t = '{low_us: 10'd500, rel_us: 10'd70, tail_us: 10'd430};
      SLOT_W0:  t = '{low_us: 10'd60,  rel_us: 10'd10, tail_us: 10'd0};
      SLOT_W1:  t = '{low_us: 10'd6,   rel_us: 10'd64, tail_us: 10'd0};
      SLOT_RD:  t = '{low_us: 10'd6,   rel_us: 10'd9,  tail_us: 10'd55};
      default:  t = '{low_us: 10'd1,   rel_us: 10'd1,  tail_us: 10'd0};
    endcase
    return t;
  endfunction

endpackage

// File: rtl/ow_tick_gen.sv
module ow_tick_gen #(
  parameter int CLK_PER_US = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int PC_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [PC_W-1:0] PC_LAST = PC_W'(CLK_PER_US - 1);

  logic [PC_W-1:0] pc;

  assign tick = (pc == PC_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pc <= '0;
    else if (restart || tick) pc <= '0;
    else                     pc <= pc + 1'b1;
  end
endmodule

// File: rtl/ow_sync2.sv
module ow_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= 1'b1;
      q    <= 1'b1;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/ow_slot_seq.sv
module ow_slot_seq
  import ow_pkg::*;
#(
  parameter int DELAY_COEF = 1,
  parameter int CNT_W      = 10
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  slot_e kind,
  input  logic  keep_sample,
  input  logic  tick,
  input  logic  line_s,
  output logic  drive_n,
  output logic  busy,
  output logic  done,
  output logic  rsp_bit
);
  phase_e          ph;
  slot_e           kind_q;
  logic            keep_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cur_len;
  logic [CNT_W-1:0] tail_len;
  logic            last;
  slot_us_t        t_us;

  assign t_us     = slot_us(kind_q);
  assign tail_len = CNT_W'(t_us.tail_us) * CNT_W'(DELAY_COEF);

  always_comb begin
    unique case (ph)
      PH_LOW:  cur_len = CNT_W'(t_us.low_us) * CNT_W'(DELAY_COEF);
      PH_REL:  cur_len = CNT_W'(t_us.rel_us) * CNT_W'(DELAY_COEF);
      PH_TAIL: cur_len = tail_len;
      default: cur_len = '0;
    endcase
  end

  assign last = tick && (cnt == cur_len - 1'b1);
  assign busy = (ph != PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= PH_IDLE;
      kind_q  <= SLOT_RST;
      keep_q  <= 1'b0;
      cnt     <= '0;
      drive_n <= 1'b1;
      done    <= 1'b0;
      rsp_bit <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (ph)
        PH_IDLE: begin
          if (start) begin
            ph      <= PH_LOW;
            kind_q  <= kind;
            keep_q  <= keep_sample;
            cnt     <= '0;
            drive_n <= 1'b0;
          end
        end
        PH_LOW: begin
          if (last) begin
            ph      <= PH_REL;
            cnt     <= '0;
            drive_n <= 1'b1;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_REL: begin
          if (last) begin
            rsp_bit <= keep_q & line_s;
            cnt     <= '0;
            if (tail_len == '0) begin
              ph   <= PH_IDLE;
              done <= 1'b1;
            end else begin
              ph <= PH_TAIL;
            end
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_TAIL: begin
          if (last) begin
            ph   <= PH_IDLE;
            done <= 1'b1;
            cnt  <= '0;
          end else if (tick) begin
            cnt <= cnt + 1'b1;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ow_slot_engine.sv
module ow_slot_engine
  import ow_pkg::*;
#(
  parameter int CLK_PER_US = 250,
  parameter int DELAY_COEF = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic [1:0] req_op,
  input  logic       req_data,
  output logic       busy,
  output logic       done,
  output logic       rsp_bit,
  output logic       ow_drive_n,
  input  logic       ow_line_i
);
  localparam int MAX_TICKS = 1000 * DELAY_COEF;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  logic  accept;
  logic  tick;
  logic  line_s;
  slot_e kind;
  logic  keep_sample;

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;

  always_comb begin
    unique case (ow_op_e'(req_op))
      OP_RESET: begin kind = SLOT_RST; keep_sample = 1'b1; end
      OP_WRITE: begin kind = req_data ? SLOT_W1 : SLOT_W0; keep_sample = 1'b0; end
      OP_READ:  begin kind = SLOT_RD; keep_sample = 1'b1; end
      OP_TOUCH: begin kind = req_data ? SLOT_RD : SLOT_W0; keep_sample = req_data; end
      default:  begin kind = SLOT_RD; keep_sample = 1'b0; end
    endcase
  end

  ow_tick_gen #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(accept), .tick(tick)
  );

  ow_sync2 u_sync (
    .clk(clk), .rst_n(rst_n), .d(ow_line_i), .q(line_s)
  );

  ow_slot_seq #(.DELAY_COEF(DELAY_COEF), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept), .kind(kind),
    .keep_sample(keep_sample), .tick(tick), .line_s(line_s),
    .drive_n(ow_drive_n), .busy(busy), .done(done), .rsp_bit(rsp_bit)
  );
endmodule

// File: rtl/ow_slot_engine_chk.sv
module ow_slot_engine_chk #(
  parameter int CLK_PER_US = 250,
  parameter int DELAY_COEF = 1
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic busy,
  input logic done,
  input logic ow_drive_n
);
  localparam int MIN_LOW = 6 * DELAY_COEF * CLK_PER_US;
  localparam int MAX_LOW = 500 * DELAY_COEF * CLK_PER_US;

  int unsigned low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           low_run <= 0;
    else if (!ow_drive_n) low_run <= low_run + 1;
    else                  low_run <= 0;
  end

  AST_ACCEPT_PULLS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!ow_drive_n && busy));                 // R2
  AST_NO_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);                                                // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                                     // R9
  AST_DONE_ENDS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));                                    // R9
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> ow_drive_n);                                               // R1
  AST_LOW_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (ow_drive_n && !$past(ow_drive_n)) |-> (low_run >= MIN_LOW));        // R7
  AST_LOW_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    !ow_drive_n |-> (low_run < MAX_LOW));                                // R6
endmodule

bind ow_slot_engine ow_slot_engine_chk #(
  .CLK_PER_US(CLK_PER_US),
  .DELAY_COEF(DELAY_COEF)
) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .busy(busy),
  .done(done),
  .ow_drive_n(ow_drive_n)
);

// File: tb/ow_slot_engine_bench.sv
module ow_slot_engine_bench;
  localparam int P = 3;
  localparam int K = 2;
  localparam int U = P * K;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_op = 2'd0;
  logic req_data = 1'b0;
  logic dev_low = 1'b0;
  logic req_ready, busy, done, rsp_bit, ow_drive_n, ow_line_i;

  int total = 0;
  int bad = 0;
  logic finished = 1'b0;

  always #2 clk = ~clk;

  assign ow_line_i = (ow_drive_n == 1'b0) ? 1'b0 : ~dev_low;

  ow_slot_engine #(.CLK_PER_US(P), .DELAY_COEF(K)) u_ow_slot_engine (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_data(req_data), .busy(busy), .done(done),
    .rsp_bit(rsp_bit), .ow_drive_n(ow_drive_n), .ow_line_i(ow_line_i)
  );

  // op, data, device pulls low, low us, total us, expected bit
  localparam int NV = 9;
  localparam logic [24:0] VEC [NV] = '{
    {2'd0, 1'b0, 1'b1, 10'd500, 10'd1000, 1'b0},  // R6 present
    {2'd0, 1'b0, 1'b0, 10'd500, 10'd1000, 1'b1},  // R6 absent
    {2'd1, 1'b1, 1'b0, 10'd6,   10'd70,   1'b0},  // R3
    {2'd1, 1'b0, 1'b0, 10'd60,  10'd70,   1'b0},  // R4
    {2'd2, 1'b0, 1'b1, 10'd6,   10'd70,   1'b0},  // R5 low
    {2'd2, 1'b0, 1'b0, 10'd6,   10'd70,   1'b1},  // R5 high
    {2'd3, 1'b1, 1'b1, 10'd6,   10'd70,   1'b0},  // R8 touch1
    {2'd3, 1'b1, 1'b0, 10'd6,   10'd70,   1'b1},  // R8 touch1
    {2'd3, 1'b0, 1'b0, 10'd60,  10'd70,   1'b0}   // R8 touch0
  };

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic run_slot(input logic [1:0] op, input logic d, input logic dl,
                          input int rel_at, input int inj_at,
                          output int lowc, output int tot, output logic b,
                          output logic rdy_hi);
    int n;
    @(negedge clk);
    dev_low = dl; req_op = op; req_data = d; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0; lowc = 0; rdy_hi = 1'b0; tot = -1; b = 1'b0;
    while (1) begin
      if (n == rel_at) dev_low = 1'b0;
      if (n == inj_at) begin req_valid = 1'b1; req_op = 2'd2; end
      if (n == inj_at + 5) req_valid = 1'b0;
      if (req_valid && req_ready) rdy_hi = 1'b1;
      if (!ow_drive_n) lowc++;
      if (done) begin tot = n; b = rsp_bit; break; end
      if (n > 20000) break;
      @(negedge clk);
      n++;
    end
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
  end

  initial begin
    int lowc, tot;
    logic b, rh;
    repeat (3) @(negedge clk);
    check(ow_drive_n == 1'b1, "R1 drive_n in reset", int'(ow_drive_n), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(ow_drive_n == 1'b1, "R1 drive_n", int'(ow_drive_n), 1);
    check(busy == 1'b0, "R1 busy", int'(busy), 0);
    check(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
    check(done == 1'b0, "R1 done", int'(done), 0);

    for (int i = 0; i < NV; i++) begin
      run_slot(VEC[i][24:23], VEC[i][22], VEC[i][21], -1, -1, lowc, tot, b, rh);
      check(lowc == int'(VEC[i][20:11]) * U, $sformatf("R7 vec%0d low", i), lowc, int'(VEC[i][20:11]) * U);
      check(tot == int'(VEC[i][10:1]) * U, $sformatf("R7 vec%0d total", i), tot, int'(VEC[i][10:1]) * U);
      check(b == VEC[i][0], $sformatf("R2 vec%0d bit", i), int'(b), int'(VEC[i][0]));
    end

    // R5 sample instant: released well before sample -> 1, at sample -> 0
    run_slot(2'd2, 1'b0, 1'b1, 15 * U - 4, -1, lowc, tot, b, rh);
    check(b == 1'b1, "R5 release before sample", int'(b), 1);
    run_slot(2'd2, 1'b0, 1'b1, 15 * U, -1, lowc, tot, b, rh);
    check(b == 1'b0, "R5 release after sample", int'(b), 0);

    // R6 presence pulse ending after the reset sample still counts present
    run_slot(2'd0, 1'b0, 1'b1, 570 * U + 10, -1, lowc, tot, b, rh);
    check(b == 1'b0, "R6 presence at sample", int'(b), 0);

    // R2 request offered mid-slot is ignored
    run_slot(2'd1, 1'b0, 1'b0, -1, 20, lowc, tot, b, rh);
    check(rh == 1'b0, "R2 ready while busy", int'(rh), 0);
    check(lowc == 60 * U, "R2 low unchanged", lowc, 60 * U);
    check(tot == 70 * U, "R2 total unchanged", tot, 70 * U);
    repeat (2 * U + 5) begin
      @(negedge clk);
      if (busy || !ow_drive_n) break;
    end
    check(busy == 1'b0, "R2 no extra slot busy", int'(busy), 0);
    check(ow_drive_n == 1'b1, "R2 no extra slot line", int'(ow_drive_n), 1);

    // R9 done lasts one cycle, busy already low with it
    run_slot(2'd1, 1'b1, 1'b0, -1, -1, lowc, tot, b, rh);
    check(busy == 1'b0, "R9 busy low at done", int'(busy), 0);
    @(negedge clk);
    check(done == 1'b0, "R9 done one cycle", int'(done), 0);

    // R1 reset mid-slot returns to idle
    @(negedge clk);
    req_op = 2'd0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(ow_drive_n == 1'b1 && busy == 1'b0, "R1 reset mid-slot", int'(busy), 0);

    summary();
  end
endmodule